// File: doc/BRIEF.md
# Streamed Neural Weight Update Engine

This block is a training coprocessor for a small neural network. A processor streams operand words into it over a FIFO-style link. For each weight to be adjusted it sends a group of four words. The block applies the delta rule in hardware and streams the adjusted weights back over a second FIFO-style link.

The input side pops a word in any cycle where the link reports data and the block still has room. Sixteen words fill four operand rows, one row for each weight. A batch then runs through four parallel multiply-add lanes. Each lane computes `new = old + rate * activation * delta` in signed Q16.16 fixed point. Fractional bits are dropped by truncation and every stage saturates.

A three-state controller runs the batch: waiting (collecting operands), calculating, then sending. While it sends, the output side offers one result per cycle and holds back whenever the downstream link is full. A bias (threshold) update uses the same path, with the processor sending 1.0 as the activation word.

Top module: `weight_update_engine`

## Requirements
- R1: After reset the block is waiting with no operands held, and both `s_read_o` and `m_write_o` are low.
- R2: While waiting with fewer than sixteen words held, `s_read_o` follows `s_exists_i` in the same cycle. It is never high when `s_exists_i` is low.
- R3: The sixteen words of a batch fill the lanes in arrival order. For lane k, word 4k is the old weight, 4k+1 the rate, 4k+2 the activation and 4k+3 the delta.
- R4: Each product is the full signed product shifted right arithmetically by 16 bits, so it truncates toward minus infinity, and then saturated to 32 bits. The lane computes `sat(old + sat(sat(rate*act)*delta))`.
- R5: The final sum and both products clamp to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow. They never wrap.
- R6: With activation 0x00010000 (1.0) the result is old + rate×delta, which makes it a bias update.
- R7: `m_write_o` is never high while `m_full_i` is high. While a result is held back, `m_data_o` stays stable.
- R8: Results leave in lane order 0 to 3, one each cycle that the link is not full. `m_write_o` is high only in the sending state, and the state code is always waiting = 00, calculating = 10 or sending = 01.
- R9: A partial batch stays held across cycles without input. The batch completes correctly when the remaining words arrive later.
- R10: No word is popped while the block is calculating or sending. Each batch therefore takes exactly sixteen words, even when more are queued behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 32 | Operand word at the head of the input link |
| s_exists_i | input | 1 | Input link holds a word |
| s_read_o | output | 1 | Pops the head word in this cycle |
| m_data_o | output | 32 | Result word |
| m_write_o | output | 1 | Result word is valid and is pushed in this cycle |
| m_full_i | input | 1 | Output link cannot take a word |

## Verification
The assertions check on every cycle the handshake rules: no pop from an empty link, no pop outside the waiting state, no push into a full link, stable data while held back, and a legal state code that matches the direction of traffic. The bench alone shows the arithmetic: operand order, truncation toward minus infinity, saturation at both ends, and bias updates. It also shows the ordering of results under random backpressure, that a partial batch survives idle gaps, and that back-to-back batches with queued input split at exactly sixteen words.

// File: rtl/wue_pkg.sv
package wue_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'b00,
    ST_CALC = 2'b10,
    ST_SEND = 2'b01
  } wue_state_e;

  localparam int unsigned WORDS_PER_UPDATE = 4;
  localparam int unsigned SLOT_OLD  = 0;
  localparam int unsigned SLOT_RATE = 1;
  localparam int unsigned SLOT_ACT  = 2;
  localparam int unsigned SLOT_DLT  = 3;
endpackage

// File: rtl/wue_operand_loader.sv
module wue_operand_loader #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                accept_en_i,
  input  logic                                clear_i,
  input  logic [DATA_W-1:0]                   s_data_i,
  input  logic                                s_exists_i,
  output logic                                s_read_o,
  output logic                                loaded_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    ops_o
);
  localparam int unsigned CNT_W = $clog2(NUM_WORDS + 1);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic [CNT_W-1:0]                cnt_q;
  logic [NUM_WORDS-1:0][DATA_W-1:0] regs_q;
  logic                            take;

  assign loaded_o = (cnt_q == CNT_W'(NUM_WORDS));
  assign take     = accept_en_i && s_exists_i && !loaded_o;
  assign s_read_o = take;
  assign ops_o    = regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (take) begin
      regs_q[cnt_q[IDX_W-1:0]] <= s_data_i;
    end
  end
endmodule

// File: rtl/wue_update_lane.sv
module wue_update_lane #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] rate_i,
  input  logic [DATA_W-1:0] act_i,
  input  logic [DATA_W-1:0] dlt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ready_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] qmul(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] sh;
    p  = $signed(a) * $signed(b);
    sh = p >>> FRAC_W;
    // in range when all bits above the result sign agree
    if ((&sh[PROD_W-1:DATA_W-1]) || !(|sh[PROD_W-1:DATA_W-1]))
      return sh[DATA_W-1:0];
    return sh[PROD_W-1] ? MIN_V : MAX_V;
  endfunction

  function automatic logic [DATA_W-1:0] qadd(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (s[DATA_W] != s[DATA_W-1])
      return s[DATA_W] ? MIN_V : MAX_V;
    return s[DATA_W-1:0];
  endfunction

  logic              v1_q, v2_q, rdy_q;
  logic [DATA_W-1:0] p1_q, old1_q, dlt1_q;
  logic [DATA_W-1:0] p2_q, old2_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      rdy_q  <= 1'b0;
      p1_q   <= '0;
      old1_q <= '0;
      dlt1_q <= '0;
      p2_q   <= '0;
      old2_q <= '0;
      res_q  <= '0;
    end else begin
      v1_q <= start_i;
      v2_q <= v1_q;
      if (start_i) begin
        p1_q   <= qmul(rate_i, act_i);
        old1_q <= old_i;
        dlt1_q <= dlt_i;
      end
      if (v1_q) begin
        p2_q   <= qmul(p1_q, dlt1_q);
        old2_q <= old1_q;
      end
      if (v2_q) res_q <= qadd(old2_q, p2_q);
      if (start_i)   rdy_q <= 1'b0;
      else if (v2_q) rdy_q <= 1'b1;
    end
  end

  assign result_o = res_q;
  assign ready_o  = rdy_q;
endmodule

// File: rtl/wue_result_sender.sv
module wue_result_sender #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]   results_i,
  input  logic                               m_full_i,
  output logic [DATA_W-1:0]                  m_data_o,
  output logic                               m_write_o,
  output logic                               busy_o,
  output logic                               done_o
);
  localparam int unsigned IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LANES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign m_write_o = active_q && !m_full_i;
  assign m_data_o  = results_i[idx_q];
  assign done_o    = m_write_o && (idx_q == LAST);
  assign busy_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (m_write_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/wue_ctrl.sv
module wue_ctrl
  import wue_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       loaded_i,
  input  logic       lanes_ready_i,
  input  logic       send_done_i,
  output logic       start_cal_o,
  output logic       start_out_o,
  output wue_state_e state_o
);
  wue_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    start_cal_o = 1'b0;
    start_out_o = 1'b0;
    unique case (state_q)
      ST_WAIT: if (loaded_i) begin
        start_cal_o = 1'b1;
        state_d     = ST_CALC;
      end
      ST_CALC: if (lanes_ready_i) begin
        start_out_o = 1'b1;
        state_d     = ST_SEND;
      end
      ST_SEND: if (send_done_i) state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/weight_update_engine.sv
module weight_update_engine
  import wue_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FRAC_W    = 16,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_exists_i,
  output logic              s_read_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_write_o,
  input  logic              m_full_i
);
  localparam int unsigned NUM_WORDS = NUM_LANES * WORDS_PER_UPDATE;

  wue_state_e                       state;
  logic                             loaded, start_cal, start_out, send_done, tx_busy;
  logic [NUM_WORDS-1:0][DATA_W-1:0] ops;
  logic [NUM_LANES-1:0][DATA_W-1:0] results;
  logic [NUM_LANES-1:0]             lane_ready;

  wue_operand_loader #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) loader_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_en_i (state == ST_WAIT),
    .clear_i     (start_cal),
    .s_data_i    (s_data_i),
    .s_exists_i  (s_exists_i),
    .s_read_o    (s_read_o),
    .loaded_o    (loaded),
    .ops_o       (ops)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned BASE = g * WORDS_PER_UPDATE;
    wue_update_lane #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) lane_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_cal),
      .old_i    (ops[BASE + SLOT_OLD]),
      .rate_i   (ops[BASE + SLOT_RATE]),
      .act_i    (ops[BASE + SLOT_ACT]),
      .dlt_i    (ops[BASE + SLOT_DLT]),
      .result_o (results[g]),
      .ready_o  (lane_ready[g])
    );
  end

  wue_result_sender #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) sender_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_out),
    .results_i (results),
    .m_full_i  (m_full_i),
    .m_data_o  (m_data_o),
    .m_write_o (m_write_o),
    .busy_o    (tx_busy),
    .done_o    (send_done)
  );

  wue_ctrl ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .loaded_i      (loaded),
    .lanes_ready_i (&lane_ready),
    .send_done_i   (send_done),
    .start_cal_o   (start_cal),
    .start_out_o   (start_out),
    .state_o       (state)
  );
endmodule

// File: rtl/wue_checker.sv
module wue_checker
  import wue_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input wue_state_e        state_i,
  input logic              tx_busy_i,
  input logic              s_exists_i,
  input logic              s_read_i,
  input logic [DATA_W-1:0] m_data_i,
  input logic              m_write_i,
  input logic              m_full_i
);
  a_r7_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_write_i |-> !m_full_i);

  a_r7_hold_during_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i && m_full_i) |=> $stable(m_data_i));

  a_r10_no_pop_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_WAIT) |-> !s_read_i);

  a_r2_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_read_i |-> s_exists_i);

  a_r8_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) || (state_i == ST_CALC) || (state_i == ST_SEND));

  a_r8_write_only_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_write_i |-> (state_i == ST_SEND));

  a_r8_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({s_read_i, m_write_i}));
endmodule

bind weight_update_engine wue_checker #(.DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state),
  .tx_busy_i  (tx_busy),
  .s_exists_i (s_exists_i),
  .s_read_i   (s_read_o),
  .m_data_i   (m_data_o),
  .m_write_i  (m_write_o),
  .m_full_i   (m_full_i)
);

// File: tb/weight_update_engine_tb_top.sv
module weight_update_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] s_data_i = '0;
  logic        s_exists_i = 1'b0;
  logic        s_read_o;
  logic [31:0] m_data_o;
  logic        m_write_o;
  logic        m_full_i = 1'b0;

  always #4 clk_i = ~clk_i;

  weight_update_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_data_i(s_data_i), .s_exists_i(s_exists_i),
    .s_read_o(s_read_o), .m_data_o(m_data_o), .m_write_o(m_write_o), .m_full_i(m_full_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] src_q[$];
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  int  popped = 0;
  int  writes = 0;
  bit  rd_seen = 1'b0;
  bit  full_rand = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sat32(input longint v);
    if (v > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] qm(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return sat32(p >>> 16);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] o, input logic [31:0] r,
                                       input logic [31:0] a, input logic [31:0] d);
    return sat32(longint'($signed(o)) + longint'($signed(qm(qm(r, a), d))));
  endfunction

  function automatic logic [31:0] rnd_word();
    case ($urandom_range(0, 3))
      0: return $urandom();
      1: return 32'(int'($urandom_range(0, 1048575)) - 524288);
      default: return 32'(int'($urandom_range(0, 262143)) - 131072);
    endcase
  endfunction

  // link models: drive at negedge, sample just after
  always @(negedge clk_i) begin
    if (rd_seen) begin
      void'(src_q.pop_front());
      popped++;
    end
    s_exists_i = (src_q.size() > 0);
    s_data_i   = s_exists_i ? src_q[0] : '0;
    m_full_i   = full_rand ? 1'($urandom_range(0, 1)) : 1'b0;
    #1;
    rd_seen = rst_ni && s_read_o;
    if (rst_ni && m_write_o) begin
      got_q.push_back(m_data_o);
      writes++;
      // R10: a batch only empties once exactly sixteen words were taken for it
      chk("R10 words popped per batch", 32'(popped % 16), 32'd0);
      if (m_full_i) chk("R7 write while full", 32'd1, 32'd0);
    end
  end

  task automatic push_group(input logic [31:0] w[4], input bit with_exp);
    foreach (w[i]) src_q.push_back(w[i]);
    if (with_exp) exp_q.push_back(model(w[0], w[1], w[2], w[3]));
  endtask

  task automatic wait_results(input int n);
    while (got_q.size() < n) @(negedge clk_i);
    #2;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) chk(req, got_q.pop_front(), exp_q.pop_front());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] g[4];
    logic [31:0] part[$];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk("R1 read low after reset", 32'(s_read_o), 32'd0);
    chk("R1 write low after reset", 32'(m_write_o), 32'd0);

    // directed batch: R3 order, R4 value, R6 bias, R5 saturation
    g = '{32'h0001_0000, 32'h0000_8000, 32'h0002_0000, 32'h0000_4000}; push_group(g, 1'b0);
    g = '{32'h0003_0000, 32'h0000_8000, 32'h0001_0000, 32'hFFFF_0000}; push_group(g, 1'b0);
    g = '{32'h7FFF_0000, 32'h0001_0000, 32'h0001_0000, 32'h0010_0000}; push_group(g, 1'b0);
    g = '{32'h8001_0000, 32'h0001_0000, 32'h0001_0000, 32'hFFF0_0000}; push_group(g, 1'b0);
    @(negedge clk_i); #2;
    chk("R2 read follows exists", 32'(s_read_o), 32'(s_exists_i));
    wait_results(4);
    chk("R3 R4 lane0 1.25", got_q.pop_front(), 32'h0001_4000);
    chk("R6 bias lane1 2.5", got_q.pop_front(), 32'h0002_8000);
    chk("R5 positive clamp", got_q.pop_front(), 32'h7FFF_FFFF);
    chk("R5 negative clamp", got_q.pop_front(), 32'h8000_0000);
    writes = 0;

    // product saturation and truncation toward minus infinity
    g = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0001_0000}; push_group(g, 1'b0);
    g = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_8000, 32'h0001_0000}; push_group(g, 1'b0);
    g = '{32'h0005_0000, 32'h0000_4000, 32'h0001_0000, 32'h0002_0000}; push_group(g, 1'b0);
    g = '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0001_0000}; push_group(g, 1'b0);
    wait_results(4);
    chk("R5 product clamp", got_q.pop_front(), 32'h7FFF_FFFF);
    chk("R4 floor truncation", got_q.pop_front(), 32'hFFFF_FFFF);
    chk("R6 bias 5+0.5", got_q.pop_front(), 32'h0005_8000);
    chk("R4 tiny product to zero", got_q.pop_front(), 32'h0000_0001);

    // R9: partial batch across an idle gap
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 4; i++) g[i] = rnd_word();
      exp_q.push_back(model(g[0], g[1], g[2], g[3]));
      foreach (g[i]) part.push_back(g[i]);
    end
    for (int i = 0; i < 7; i++) src_q.push_back(part[i]);
    repeat (20) @(negedge clk_i);
    #2;
    chk("R9 nothing sent for partial batch", 32'(got_q.size()), 32'd0);
    for (int i = 7; i < 16; i++) src_q.push_back(part[i]);
    wait_results(4);
    drain("R9 completed partial batch");

    // R10 R8 R7: two batches queued back to back under backpressure
    full_rand = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 4; i++) g[i] = rnd_word();
      push_group(g, 1'b1);
    end
    wait_results(8);
    drain("R8 R10 back to back order");

    // random batches with random backpressure
    for (int b = 0; b < 25; b++) begin
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < 4; i++) g[i] = rnd_word();
        if ($urandom_range(0, 4) == 0) g[2] = 32'h0001_0000;
        push_group(g, 1'b1);
      end
    end
    wait_results(100);
    drain("R4 R8 random batches");
    full_rand = 1'b0;
    repeat (4) @(negedge clk_i);
    #2;
    chk("R8 idle after all batches", 32'(m_write_o), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule